// File: doc/BRIEF.md
# Downstream Bus Busy Sensor

This block sits beside a two-master bus selector and watches the shared downstream two-wire bus. It brings the clock and data lines into the system clock domain and follows START and STOP conditions to keep a busy flag. A transfer counts as open from a START until the matching STOP, or until both lines have rested high for a programmable number of cycles.

When the selector hands the bus to the other master, it pulses `switch_i`. If the downstream bus is busy at that moment, the block latches `flag_o`. That flag becomes an interrupt which tells the new owner to run its own recovery on the bus.

The sensor only works while the selector's built-in recovery sequence is turned off. While that sequence is on, the busy state is held idle and no flag can be raised. Software can mask the flag and clear it.

Top module: `bus_busy_sensor`

## Requirements
- R1: After reset, `busy_o` and `flag_o` are both 0.
- R2: Data falling while the clock is high is a START. It sets `busy_o`, which goes high on the third rising clock edge after the change is first sampled: two synchronizer stages, then the busy register.
- R3: Data rising while the clock is high is a STOP. It clears `busy_o` with the same three-edge latency as R2.
- R4: Data changes while the clock is low leave `busy_o` unchanged.
- R5: While busy, if both synchronized lines are seen high on `idle_limit_i` consecutive cycles, `busy_o` clears. A limit of 0 disables this timeout.
- R6: While the sensor is enabled and unmasked, a `switch_i` cycle with `busy_o` high sets `flag_o` on the next edge. The flag then stays set until it is cleared.
- R7: A `switch_i` cycle while `busy_o` is low does not set `flag_o`.
- R8: While `recovery_en_i` is 1, `busy_o` is 0 from the next edge on, and `flag_o` cannot be set.
- R9: While `mask_i` is 1, a switch during a busy bus does not set `flag_o`.
- R10: `clear_i` clears `flag_o` on the next edge. If a flag-setting switch happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Downstream clock line, asynchronous |
| sda_i | input | 1 | Downstream data line, asynchronous |
| recovery_en_i | input | 1 | Built-in recovery enabled; disables the sensor |
| idle_limit_i | input | TIMEOUT_W | Number of both-high cycles before busy times out; 0 turns the timeout off |
| switch_i | input | 1 | One-cycle pulse marking a channel switch |
| mask_i | input | 1 | Blocks the flag from being set |
| clear_i | input | 1 | Clears the flag |
| busy_o | output | 1 | Downstream transfer in progress |
| flag_o | output | 1 | A switch happened during a busy bus |

## Verification
On every cycle, the assertions check these rules:
- a detected START is followed by busy, and a lone STOP by idle;
- START and STOP are never reported together;
- a disabled sensor always reads idle;
- the flag rises only after a qualifying switch, and never while masked.

The exact three-edge latency through the synchronizers, the counting of the idle timeout (including the limit-0 case), data toggles while the clock is low, and the set-over-clear priority are shown only by the bench's scenarios, which it compares against a behavioural model on every clock.

// File: rtl/bsens_pkg.sv
package bsens_pkg;
  typedef enum int unsigned {
    LN_SCL = 0,
    LN_SDA = 1
  } line_e;

  localparam int unsigned NUM_LINES = 2;

  // synchronized level plus its value one cycle earlier
  typedef struct packed {
    logic lvl;
    logic prev;
  } line_t;
endpackage

// File: rtl/bsens_sync.sv
module bsens_sync
  import bsens_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned N      = NUM_LINES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   raw_i,
  output line_t [N-1:0]  ln_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [DEPTH-1:0] sh_q;
    // idle bus level is high: reset to 1 so no edge is seen at release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[DEPTH-2:0], raw_i[g]};
    end
    assign ln_o[g].lvl  = sh_q[STAGES-1];
    assign ln_o[g].prev = sh_q[STAGES];
  end
endmodule

// File: rtl/bsens_cond.sv
module bsens_cond
  import bsens_pkg::*;
(
  input  line_t scl_i,
  input  line_t sda_i,
  output logic  start_o,
  output logic  stop_o,
  output logic  both_hi_o
);
  logic scl_held_hi, sda_fall, sda_rise;

  always_comb begin
    scl_held_hi = scl_i.lvl & scl_i.prev;
    sda_fall    = sda_i.prev & ~sda_i.lvl;
    sda_rise    = ~sda_i.prev & sda_i.lvl;
    start_o     = scl_held_hi & sda_fall;
    stop_o      = scl_held_hi & sda_rise;
    both_hi_o   = scl_i.lvl & sda_i.lvl;
  end
endmodule

// File: rtl/bsens_busy.sv
module bsens_busy #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          both_hi_i,
  input  logic [TW-1:0] limit_i,
  output logic          busy_o
);
  logic          busy_q;
  logic [TW-1:0] cnt_q;
  logic [TW:0]   cnt_nx;
  logic          limit_on, idle_run, timeout;

  always_comb begin
    cnt_nx   = {1'b0, cnt_q} + 1'b1;
    limit_on = (limit_i != '0);
    idle_run = busy_q & both_hi_i & limit_on;
    timeout  = idle_run & (cnt_nx >= {1'b0, limit_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (stop_i || timeout) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (idle_run) begin
      cnt_q  <= cnt_nx[TW-1:0];
    end else begin
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i) |=> busy_q) else $error("a_r2_start_sets_busy");

  a_r3_stop_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !busy_q) else $error("a_r3_stop_clears_busy");

  a_r4_cond_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_i, stop_i})) else $error("a_r4_cond_exclusive");

  a_r8_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_q) else $error("a_r8_disabled_idle");
endmodule

// File: rtl/bus_busy_sensor.sv
module bus_busy_sensor
  import bsens_pkg::*;
#(
  parameter int unsigned TIMEOUT_W   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 recovery_en_i,
  input  logic [TIMEOUT_W-1:0] idle_limit_i,
  input  logic                 switch_i,
  input  logic                 mask_i,
  input  logic                 clear_i,
  output logic                 busy_o,
  output logic                 flag_o
);
  line_t [NUM_LINES-1:0] ln;
  logic [NUM_LINES-1:0]  raw;
  logic start, stop, both_hi, busy, sense_en, flag_q, flag_set;

  always_comb begin
    raw         = '0;
    raw[LN_SCL] = scl_i;
    raw[LN_SDA] = sda_i;
  end

  bsens_sync #(.STAGES(SYNC_STAGES), .N(NUM_LINES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .ln_o  (ln)
  );

  bsens_cond i_cond (
    .scl_i    (ln[LN_SCL]),
    .sda_i    (ln[LN_SDA]),
    .start_o  (start),
    .stop_o   (stop),
    .both_hi_o(both_hi)
  );

  assign sense_en = ~recovery_en_i;

  bsens_busy #(.TW(TIMEOUT_W)) i_busy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sense_en),
    .start_i  (start),
    .stop_i   (stop),
    .both_hi_i(both_hi),
    .limit_i  (idle_limit_i),
    .busy_o   (busy)
  );

  assign flag_set = sense_en & ~mask_i & switch_i & busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (clear_i)  flag_q <= 1'b0;
  end

  assign busy_o = busy;
  assign flag_o = flag_q;

  a_r6_switch_busy_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_i && busy_o && !mask_i && !recovery_en_i) |=> flag_o)
    else $error("a_r6_switch_busy_flags");

  a_r7_no_spurious_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(switch_i && busy_o)) |=> !flag_o)
    else $error("a_r7_no_spurious_flag");

  a_r9_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && !flag_o) |=> !flag_o) else $error("a_r9_mask_blocks");
endmodule

// File: tb/test_bus_busy_sensor.sv
module test_bus_busy_sensor;
  localparam int CLK_P = 10;
  localparam int TW    = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1, recov = 1'b0, sw = 1'b0, mask = 1'b0, clr = 1'b0;
  logic [TW-1:0] limit = 16'd5;
  logic busy_o, flag_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  bus_busy_sensor #(.TIMEOUT_W(TW), .SYNC_STAGES(2)) i_bus_busy_sensor (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .recovery_en_i(recov), .idle_limit_i(limit), .switch_i(sw),
    .mask_i(mask), .clear_i(clr), .busy_o(busy_o), .flag_o(flag_o));

  // behavioural reference model
  bit qc[$] = '{1, 1, 1};
  bit qd[$] = '{1, 1, 1};
  bit m_busy = 0, m_flag = 0;
  int m_cnt = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      qc = '{1, 1, 1}; qd = '{1, 1, 1};
      m_busy = 0; m_flag = 0; m_cnt = 0;
    end else begin
      bit st, sp, nb, nf;
      int nc;
      st = qc[1] && qc[2] && qd[2] && !qd[1];
      sp = qc[1] && qc[2] && !qd[2] && qd[1];
      nb = m_busy; nc = m_cnt; nf = m_flag;
      if (!recov && !mask && sw && m_busy) nf = 1;
      else if (clr) nf = 0;
      if (recov) begin nb = 0; nc = 0; end
      else if (st) begin nb = 1; nc = 0; end
      else if (sp) begin nb = 0; nc = 0; end
      else if (m_busy && qc[1] && qd[1] && limit != 0) begin
        if (nc + 1 >= int'(limit)) begin nb = 0; nc = 0; end
        else nc = nc + 1;
      end else nc = 0;
      m_busy = nb; m_cnt = nc; m_flag = nf;
      qc.push_front(scl); void'(qc.pop_back());
      qd.push_front(sda); void'(qd.pop_back());
    end
  end

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      check(cur_req, busy_o, m_busy, "busy_o vs model");
      check(cur_req, flag_o, m_flag, "flag_o vs model");
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(logic c, logic d, int n);
    @(negedge clk); scl = c; sda = d;
    wait_n(n);
  endtask

  task automatic pulse_sw(logic with_clr);
    @(negedge clk); sw = 1'b1; clr = with_clr;
    @(negedge clk); sw = 1'b0; clr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    check("R1", busy_o, 1'b0, "busy after reset");
    check("R1", flag_o, 1'b0, "flag after reset");

    cur_req = "R2";
    lines(1, 1, 3);
    lines(1, 0, 1);
    wait_n(1);
    check("R2", busy_o, 1'b0, "busy before sync latency");
    wait_n(2);
    check("R2", busy_o, 1'b1, "busy after START");

    cur_req = "R4";
    lines(0, 0, 2);
    for (int i = 0; i < 4; i++) begin
      lines(0, i[0], 2);
      lines(1, i[0], 1);
      lines(0, i[0], 1);
    end
    lines(0, 0, 4);
    check("R4", busy_o, 1'b1, "busy across data bits");

    cur_req = "R6";
    pulse_sw(1'b0);
    check("R6", flag_o, 1'b1, "flag after busy switch");
    wait_n(3);
    check("R6", flag_o, 1'b1, "flag holds");

    cur_req = "R10";
    pulse_clr();
    check("R10", flag_o, 1'b0, "flag cleared");
    pulse_sw(1'b1);
    check("R10", flag_o, 1'b1, "set wins over clear");
    pulse_clr();

    cur_req = "R9";
    mask = 1'b1;
    pulse_sw(1'b0);
    wait_n(1);
    check("R9", flag_o, 1'b0, "masked switch");
    mask = 1'b0;

    cur_req = "R3";
    lines(1, 0, 3);
    lines(1, 1, 4);
    check("R3", busy_o, 1'b0, "idle after STOP");

    cur_req = "R7";
    pulse_sw(1'b0);
    wait_n(1);
    check("R7", flag_o, 1'b0, "switch on idle bus");

    cur_req = "R5";
    lines(1, 0, 4);
    check("R5", busy_o, 1'b1, "busy before timeout");
    lines(0, 0, 1);
    lines(0, 1, 1);
    lines(1, 1, 4);
    check("R5", busy_o, 1'b1, "still busy mid timeout");
    wait_n(4);
    check("R5", busy_o, 1'b0, "cleared by timeout");

    limit = '0;
    lines(1, 0, 4);
    lines(0, 0, 1);
    lines(0, 1, 1);
    lines(1, 1, 20);
    check("R5", busy_o, 1'b1, "limit 0 never times out");

    cur_req = "R8";
    @(negedge clk); recov = 1'b1;
    wait_n(1);
    check("R8", busy_o, 1'b0, "disabled reads idle");
    pulse_sw(1'b0);
    check("R8", flag_o, 1'b0, "disabled no flag");
    lines(1, 0, 4);
    check("R8", busy_o, 1'b0, "START ignored while disabled");
    lines(1, 1, 3);
    @(negedge clk); recov = 1'b0;
    wait_n(3);

    finish_run();
  end
endmodule